// File: doc/BRIEF.md
# Level-Triggered Interrupt Sequencer

This block decides when a single-vector CPU takes an interrupt. It keeps a pending flag and an enable bit for each interrupt source, plus a global in-service bit. A source event sets its flag, and the flag stays set until firmware clears it. Firmware can read both register banks and write them. When at least one source has both its flag and its enable set, the sequencer waits for the end-of-instruction strobe from the core. It then asks the fetch logic to put a call to vector address 1 in place of the next instruction. At the same time it sets the in-service bit, so that no second interrupt nests inside the first.

The in-service bit is released with a deliberate delay. When the core reports that a return-from-interrupt has finished, the sequencer waits through one more main-program instruction before it will accept anything. The request is level-sensitive, so a flag left set keeps asking for service. A source that firmware forgets to clear is therefore serviced again, but only after exactly one main-program instruction.

The controller is a four-state machine. The states are:
- IDLE: in-service clear, waiting for a request.
- INJECT: a one-cycle pulse on the call-injection output.
- SERVICE: the handler is running.
- RETURN: the return has finished and the one guaranteed main-program instruction is running.

The transitions are:
- IDLE to INJECT on an end-of-instruction strobe while a request is present.
- INJECT to SERVICE unconditionally.
- SERVICE to RETURN on an end-of-instruction strobe that comes together with the return strobe.
- RETURN to INJECT on an end-of-instruction strobe while a request is still present.
- RETURN to IDLE on an end-of-instruction strobe with no request.

Top module: `irq_sequencer`

## Requirements
- R1: After reset, every pending flag and every enable bit is 0, and both `in_service` and `inject_call` are 0.
- R2: A high `src_evt[i]` sets pending flag i on the next clock edge. The flag stays set until it is cleared. A write with `reg_sel`=1 loads `reg_wdata` into the enable register. Both registers are readable on `flag_rd` and `en_rd`, one bit per source, with bit i belonging to source i.
- R3: A write with `reg_sel`=0 clears every pending flag whose `reg_wdata` bit is 1 and leaves the other flags alone. If an event for a source arrives in the same cycle as its clear, the flag ends up set.
- R4: A request exists only when some source has both its flag and its enable set. A flag with its enable at 0 never causes an injection.
- R5: A request is accepted only at an `instr_end` strobe. `inject_call` goes high in the cycle after that strobe and stays high for exactly one cycle. No injection happens while `instr_end` stays low.
- R6: `in_service` rises together with `inject_call`. While the handler runs, no further injection happens, even if requests are pending and `instr_end` strobes arrive.
- R7: An `instr_end` strobe together with `reti_done` during service ends the handler, but `in_service` stays 1. At the next `instr_end`, `in_service` returns to 0 if no request is present. If a request is present, a new injection follows directly.
- R8: Requests are level-sensitive. A flag left set through a return is serviced again after exactly one main-program instruction.
- R9: `reti_done` without `instr_end`, or `reti_done` while not in service, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_evt | input | NSRC | Per-source event inputs; each sets its pending flag |
| reg_we | input | 1 | Firmware register write strobe |
| reg_sel | input | 1 | Write target: 0 = flag clear mask, 1 = enable register |
| reg_wdata | input | NSRC | Firmware write data |
| flag_rd | output | NSRC | Pending flag readback |
| en_rd | output | NSRC | Enable register readback |
| instr_end | input | 1 | Strobe: the current instruction is finishing |
| reti_done | input | 1 | Strobe: the finishing instruction is a return-from-interrupt |
| inject_call | output | 1 | One-cycle request to the fetch logic to insert a call to address 1 |
| in_service | output | 1 | Global in-service bit that blocks nesting |

## Verification
The bench sweeps every combination of pending flags and enables for four sources. A design that ANDs or ORs the wrong vectors would inject for a disabled flag, or would fail to inject for an enabled one. It also targets the following cases:
- A clear that collides with a new event. Letting the clear win would silently lose that event.
- Strobes arriving during service. A design that let them through would nest the handler.
- The return sequence with a flag left set. A design that released the in-service bit at the return itself would re-enter with no main-program instruction in between. A design that waited one instruction too long would leave a pending interrupt unserviced for an extra instruction.
- Stray return strobes, with no end of instruction or outside service. These must not end service early.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_INJECT,
        ST_SERVICE,
        ST_RETURN
    } seq_state_e;
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
    parameter int NSRC = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_evt,
    input  logic            clr_we,
    input  logic            en_we,
    input  logic [NSRC-1:0] wdata,
    output logic [NSRC-1:0] flag_o,
    output logic [NSRC-1:0] en_o,
    output logic            req_o
);
    logic [NSRC-1:0] flag_q;
    logic [NSRC-1:0] en_q;
    logic [NSRC-1:0] clr_mask;

    assign clr_mask = clr_we ? wdata : '0;

    // Event wins over a clear in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else begin
            flag_q <= (flag_q & ~clr_mask) | src_evt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (en_we) begin
            en_q <= wdata;
        end
    end

    assign flag_o = flag_q;
    assign en_o   = en_q;
    assign req_o  = |(flag_q & en_q);

    for (genvar i = 0; i < NSRC; i++) begin : g_chk
        AST_EVT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
            src_evt[i] |=> flag_o[i]); // R3
        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_o[i] && !(clr_we && wdata[i])) |=> flag_o[i]); // R2
        AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_we && wdata[i] && !src_evt[i]) |=> !flag_o[i]); // R3
    end
endmodule

// File: rtl/irq_ctrl_fsm.sv
module irq_ctrl_fsm
    import irq_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic instr_end,
    input  logic reti_done,
    input  logic req,
    output logic inject_call,
    output logic in_service
);
    seq_state_e state_q;
    seq_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (instr_end && req) state_d = ST_INJECT;
            end
            ST_INJECT: begin
                state_d = ST_SERVICE;
            end
            ST_SERVICE: begin
                if (instr_end && reti_done) state_d = ST_RETURN;
            end
            ST_RETURN: begin
                if (instr_end) state_d = req ? ST_INJECT : ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        inject_call = 1'b0;
        in_service  = 1'b1;
        unique case (state_q)
            ST_IDLE:    in_service  = 1'b0;
            ST_INJECT:  inject_call = 1'b1;
            ST_SERVICE: in_service  = 1'b1;
            ST_RETURN:  in_service  = 1'b1;
            default:    in_service  = 1'b0;
        endcase
    end

    AST_INJECT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        inject_call |=> !inject_call); // R5
    AST_ACCEPT_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_service && instr_end && req) |=> inject_call); // R5
    AST_NO_SPONTANEOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_service && !instr_end) |=> !inject_call); // R5
    AST_INJECT_SETS_ISVC: assert property (@(posedge clk) disable iff (!rst_n)
        inject_call |-> in_service); // R6
    AST_NO_NEST: assert property (@(posedge clk) disable iff (!rst_n)
        (in_service && !inject_call && !(instr_end && reti_done) && state_q == ST_SERVICE)
        |=> !inject_call && in_service); // R6
    AST_RETURN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SERVICE && instr_end && reti_done) |=> in_service && !inject_call); // R7
    AST_IDLE_IGNORES_RETI: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_service && !instr_end) |=> !in_service); // R9
endmodule

// File: rtl/irq_sequencer.sv
module irq_sequencer #(
    parameter int NSRC = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_evt,
    input  logic            reg_we,
    input  logic            reg_sel,
    input  logic [NSRC-1:0] reg_wdata,
    output logic [NSRC-1:0] flag_rd,
    output logic [NSRC-1:0] en_rd,
    input  logic            instr_end,
    input  logic            reti_done,
    output logic            inject_call,
    output logic            in_service
);
    logic clr_we;
    logic en_we;
    logic req;

    assign clr_we = reg_we && !reg_sel;
    assign en_we  = reg_we && reg_sel;

    irq_src_bank #(.NSRC(NSRC)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_evt(src_evt),
        .clr_we (clr_we),
        .en_we  (en_we),
        .wdata  (reg_wdata),
        .flag_o (flag_rd),
        .en_o   (en_rd),
        .req_o  (req)
    );

    irq_ctrl_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .instr_end  (instr_end),
        .reti_done  (reti_done),
        .req        (req),
        .inject_call(inject_call),
        .in_service (in_service)
    );

    AST_REQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_service && instr_end && ((flag_rd & en_rd) == '0)) |=> !inject_call); // R4
endmodule

// File: tb/tb_irq_sequencer.sv
module tb_irq_sequencer;
    localparam int CLK_P = 10;
    localparam int NSRC  = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] src_evt = '0;
    logic            reg_we = 1'b0;
    logic            reg_sel = 1'b0;
    logic [NSRC-1:0] reg_wdata = '0;
    logic [NSRC-1:0] flag_rd;
    logic [NSRC-1:0] en_rd;
    logic            instr_end = 1'b0;
    logic            reti_done = 1'b0;
    logic            inject_call;
    logic            in_service;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    irq_sequencer #(.NSRC(NSRC)) dut (
        .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .reg_we(reg_we),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .flag_rd(flag_rd),
        .en_rd(en_rd), .instr_end(instr_end), .reti_done(reti_done),
        .inject_call(inject_call), .in_service(in_service)
    );

    always #(CLK_P/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !done) begin
            errors = errors + 1;
            $display("FAIL watchdog act=%0d exp=<100000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // One clock edge, then settle; all strobes drop afterwards.
    task automatic tick();
        @(posedge clk);
        #1;
        src_evt = '0; reg_we = 1'b0; instr_end = 1'b0; reti_done = 1'b0;
    endtask

    task automatic wr(input logic sel, input logic [NSRC-1:0] d);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        tick();
    endtask

    task automatic iend(input logic reti);
        instr_end = 1'b1; reti_done = reti;
        tick();
    endtask

    initial begin
        repeat (2) @(posedge clk);
        #1;
        chk("R1 flags", flag_rd, 0);
        chk("R1 enables", en_rd, 0);
        chk("R1 in_service", in_service, 0);
        chk("R1 inject", inject_call, 0);
        rst_n = 1'b1;
        tick();

        // Near-exhaustive sweep of flag x enable patterns (R2, R4, R5, R6, R7)
        for (int e = 0; e < (1 << NSRC); e++) begin
            for (int f = 0; f < (1 << NSRC); f++) begin
                logic exp_req;
                exp_req = ((f & e) != 0);
                wr(1'b1, e[NSRC-1:0]);
                src_evt = f[NSRC-1:0];
                tick();
                chk("R2 flag readback", flag_rd, f);
                chk("R2 enable readback", en_rd, e);
                chk("R5 no inject before end", inject_call, 0);
                iend(1'b0);
                chk("R4 inject vs request", inject_call, exp_req);
                chk("R6 in_service with inject", in_service, exp_req);
                if (exp_req) begin
                    tick();
                    chk("R5 single-cycle pulse", inject_call, 0);
                    iend(1'b0);
                    chk("R6 no nesting", inject_call, 0);
                    chk("R6 still in service", in_service, 1);
                    wr(1'b0, '1);
                    chk("R3 clear all", flag_rd, 0);
                    iend(1'b1);
                    chk("R7 held after return", in_service, 1);
                    iend(1'b0);
                    chk("R7 released", in_service, 0);
                    chk("R7 no reinject", inject_call, 0);
                end else begin
                    wr(1'b0, '1);
                end
            end
        end

        // R3: clear colliding with event
        wr(1'b1, '0);
        src_evt = 4'b0011; tick();
        reg_we = 1'b1; reg_sel = 1'b0; reg_wdata = 4'b0011; src_evt = 4'b0001;
        tick();
        chk("R3 event beats clear", flag_rd, 4'b0001);
        wr(1'b0, 4'b0001);
        chk("R3 clear only masked", flag_rd, 4'b0000);

        // R5: pending request waits for instr_end
        wr(1'b1, 4'b0100);
        src_evt = 4'b0100; tick();
        repeat (5) tick();
        chk("R5 held without strobe", inject_call, 0);
        chk("R5 idle without strobe", in_service, 0);

        // R8/R7: flag left set retriggers after exactly one instruction
        iend(1'b0);
        chk("R5 accepted", inject_call, 1);
        tick();
        iend(1'b0);
        iend(1'b1);
        chk("R8 no inject at return", inject_call, 0);
        chk("R7 in_service after return", in_service, 1);
        iend(1'b0);
        chk("R8 retrigger after one instr", inject_call, 1);
        tick();
        // R9: stray reti without instr_end
        reti_done = 1'b1; tick();
        iend(1'b0);
        chk("R9 stray reti ignored", in_service, 1);
        iend(1'b0);
        chk("R9 still in service", in_service, 1);
        chk("R9 no inject", inject_call, 0);
        wr(1'b0, '1);
        iend(1'b1);
        iend(1'b0);
        chk("R7 released to idle", in_service, 0);
        // R9: reti while idle
        iend(1'b1);
        chk("R9 idle reti ignored", in_service, 0);
        chk("R9 idle reti no inject", inject_call, 0);
        // R4: disabled flag alone
        wr(1'b1, 4'b1000);
        src_evt = 4'b0111; tick();
        iend(1'b0);
        chk("R4 disabled never injects", inject_call, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule